// File: doc/BRIEF.md
# Compare Event Timer Channel

This block is a single timer channel that produces timed events for an operating-system tick or a delay service. A free-running up-counter advances once for each pulse of a slow tick enable, nominally 32768 pulses per second. When the next count would equal a programmable compare value, the counter returns to zero and a compare flag latches. That flag can drive an interrupt line.

Software configures the channel through a small word-addressed register port. In periodic mode the channel keeps counting after every match, so an event repeats every compare-value ticks. For a 100 Hz tick this compare value is (32768 + 50) / 100 = 328. In one-shot mode the channel stops its own clock on the match. To arm a delay of N ticks, software writes N to the compare register and then writes enable together with trigger to the control register. Valid delays run from 1 to 65535 ticks, which is just under two seconds. Before a mode change, software masks all interrupts and disables the channel.

Top module: `cmp_event_timer`

## Requirements
- R1: After reset the count, compare value, mode bit, flags and interrupt mask are all zero, the channel is stopped and `irq` is low.
- R2: While running, the count rises by one on each cycle with `tick_en` high. It holds when stopped, on cycles without a tick, and on cycles that carry a control write. The count reads back at address 7.
- R3: A tick for which count+1 (modulo 2^CNT_W) equals the compare value sets the count to zero and sets status bit 0. A compare value of 0 matches on the wrap, after 2^CNT_W ticks.
- R4: With mode bit 0 clear (periodic), the channel keeps running after a match and raises an event every compare-value ticks.
- R5: With mode bit 0 set (one-shot), a match leaves the count at zero and stops the channel. No further tick advances it until it is re-enabled.
- R6: A write to address 2 is a control command: bit 0 enables, bit 1 disables, bit 2 triggers. A trigger zeroes the count whether or not the channel runs. If enable and disable are written together, disable wins.
- R7: A tick that advances the count from all-ones to zero sets status bit 1. This holds whether or not that tick is also a compare match.
- R8: Reading address 3 returns the compare flag in bit 0, the wrap flag in bit 1 and the running state in bit 2, on `rdata` in the cycle after `rd_en`. The read clears bits 0 and 1, except that a flag raised at the same edge stays set.
- R9: Writing address 4 sets mask bits wherever a 1 is written, and writing address 5 clears them. Address 6 reads the mask back. `irq` is high exactly when some flag is set and its mask bit is set.
- R10: Address 0 holds the mode bit and address 1 holds the compare value, and both read back. Writes to addresses 3, 6 and 7 change nothing. Reads of addresses 2, 4 and 5 return zero, and `rdata` is zero in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Slow tick enable, one cycle per count step |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Interrupt, flags gated by the mask |

## Verification
The bench builds the channel with its default widths, a 16-bit counter and 16-bit data. With these widths a full wrap takes 65536 ticks, which fits easily within the run. The bench can therefore exercise the wrap flag on its own, and the compare value of zero that matches only on the wrap, with one tick per cycle. The small compare values used in the random phase make periodic and one-shot matches frequent. Those matches then collide often with status reads and control writes at the same edge.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;

  localparam int ADDR_W    = 3;
  localparam int NUM_FLAGS = 2;

  // flag positions, shared by the status word and the interrupt mask
  localparam int FLG_CMP  = 0;
  localparam int FLG_WRAP = 1;
  localparam int ST_RUN   = 2;

  // control word bits
  localparam int CTL_EN   = 0;
  localparam int CTL_DIS  = 1;
  localparam int CTL_TRIG = 2;

  // mode word bit
  localparam int MODE_STOP = 0;

  typedef enum logic [ADDR_W-1:0] {
    A_MODE  = 3'd0,
    A_CMP   = 3'd1,
    A_CTRL  = 3'd2,
    A_STAT  = 3'd3,
    A_IEN   = 3'd4,
    A_IDIS  = 3'd5,
    A_IMASK = 3'd6,
    A_COUNT = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic trig;
    logic dis;
    logic en;
  } chan_cmd_t;

endpackage

// File: rtl/evtmr_count.sv
module evtmr_count #(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 cmd_vld,
  input  evtmr_pkg::chan_cmd_t cmd,
  input  logic                 stop_on_match,
  input  logic [CNT_W-1:0]     cmp_val,
  output logic [CNT_W-1:0]     cnt,
  output logic                 running,
  output logic                 cmp_hit,
  output logic                 wrap_hit
);

  // next count value, wrapping modulo 2^CNT_W
  function automatic logic [CNT_W-1:0] step_up(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  // true when the next step wraps to zero
  function automatic logic at_top(input logic [CNT_W-1:0] v);
    return &v;
  endfunction

  logic advance;

  // a control write owns the cycle; a tick in the same cycle is dropped
  assign advance  = running && tick_en && !cmd_vld;
  assign cmp_hit  = advance && (step_up(cnt) == cmp_val);
  assign wrap_hit = advance && at_top(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (cmd_vld) begin
      if (cmd.trig) cnt <= '0;
      if (cmd.dis)     running <= 1'b0;
      else if (cmd.en) running <= 1'b1;
    end else if (advance) begin
      if (cmp_hit) begin
        cnt <= '0;
        if (stop_on_match) running <= 1'b0;
      end else begin
        cnt <= step_up(cnt);
      end
    end
  end

  assert_dis_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && cmd.dis |=> !running);

  assert_trig_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && cmd.trig |=> cnt == '0);

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !cmp_hit |=> cnt == step_up($past(cnt)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !advance && !cmd_vld |=> $stable(cnt));

  assert_periodic_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit && !stop_on_match |=> running && cnt == '0);

  assert_oneshot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit && stop_on_match |=> !running && cnt == '0);

endmodule

// File: rtl/evtmr_flags.sv
module evtmr_flags #(
  parameter int NF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_vec,
  input  logic          clr,
  input  logic [NF-1:0] mask,
  output logic [NF-1:0] flags,
  output logic          irq
);

  // a read-clear and a new event at the same edge: the event wins
  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (clr ? '0 : flags) | set_vec;
  end

  assign irq = |(flags & mask);

  for (genvar i = 0; i < NF; i++) begin : g_chk
    assert_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flags[i]);
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !set_vec[i] |=> !flags[i]);
  end

endmodule

// File: rtl/evtmr_regs.sv
module evtmr_regs #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int NF     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [evtmr_pkg::ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [NF-1:0]                flags,
  input  logic                         running,
  input  logic [CNT_W-1:0]             cnt,
  output logic                         stop_on_match,
  output logic [CNT_W-1:0]             cmp_val,
  output logic                         cmd_vld,
  output evtmr_pkg::chan_cmd_t         cmd,
  output logic [NF-1:0]                mask,
  output logic                         stat_rd,
  output logic [DATA_W-1:0]            rdata
);
  import evtmr_pkg::*;

  logic wr_mode, wr_cmp, wr_ien, wr_idis;
  logic [DATA_W-1:0] rd_mux;

  assign wr_mode = wr_en && (addr == A_MODE);
  assign wr_cmp  = wr_en && (addr == A_CMP);
  assign wr_ien  = wr_en && (addr == A_IEN);
  assign wr_idis = wr_en && (addr == A_IDIS);
  assign cmd_vld = wr_en && (addr == A_CTRL);
  assign stat_rd = rd_en && (addr == A_STAT);

  assign cmd.trig = wdata[CTL_TRIG];
  assign cmd.dis  = wdata[CTL_DIS];
  assign cmd.en   = wdata[CTL_EN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_on_match <= 1'b0;
      cmp_val       <= '0;
      mask          <= '0;
    end else begin
      if (wr_mode) stop_on_match <= wdata[MODE_STOP];
      if (wr_cmp)  cmp_val <= wdata[CNT_W-1:0];
      if (wr_ien)       mask <= mask | wdata[NF-1:0];
      else if (wr_idis) mask <= mask & ~wdata[NF-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_MODE:  rd_mux[MODE_STOP] = stop_on_match;
      A_CMP:   rd_mux[CNT_W-1:0] = cmp_val;
      A_STAT: begin
        rd_mux[NF-1:0]  = flags;
        rd_mux[ST_RUN]  = running;
      end
      A_IMASK: rd_mux[NF-1:0] = mask;
      A_COUNT: rd_mux[CNT_W-1:0] = cnt;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
    else            rdata <= '0;
  end

  assert_mask_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ien |=> (mask & $past(wdata[NF-1:0])) == $past(wdata[NF-1:0]));

  assert_mask_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idis |=> (mask & $past(wdata[NF-1:0])) == '0);

  assert_cmp_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cmp |=> $stable(cmp_val));

  assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rdata == '0);

endmodule

// File: rtl/cmp_event_timer.sv
module cmp_event_timer #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick_en,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [evtmr_pkg::ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rdata,
  output logic                         irq
);
  import evtmr_pkg::*;

  localparam int NF = NUM_FLAGS;

  logic             stop_on_match;
  logic [CNT_W-1:0] cmp_val;
  logic [CNT_W-1:0] cnt;
  logic             running;
  logic             cmd_vld;
  chan_cmd_t        cmd;
  logic             cmp_hit;
  logic             wrap_hit;
  logic [NF-1:0]    set_vec;
  logic [NF-1:0]    flags;
  logic [NF-1:0]    irq_mask;
  logic             stat_rd;

  always_comb begin
    set_vec           = '0;
    set_vec[FLG_CMP]  = cmp_hit;
    set_vec[FLG_WRAP] = wrap_hit;
  end

  evtmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .NF(NF)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .rd_en         (rd_en),
    .addr          (addr),
    .wdata         (wdata),
    .flags         (flags),
    .running       (running),
    .cnt           (cnt),
    .stop_on_match (stop_on_match),
    .cmp_val       (cmp_val),
    .cmd_vld       (cmd_vld),
    .cmd           (cmd),
    .mask          (irq_mask),
    .stat_rd       (stat_rd),
    .rdata         (rdata)
  );

  evtmr_count #(.CNT_W(CNT_W)) u_count (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_en       (tick_en),
    .cmd_vld       (cmd_vld),
    .cmd           (cmd),
    .stop_on_match (stop_on_match),
    .cmp_val       (cmp_val),
    .cnt           (cnt),
    .running       (running),
    .cmp_hit       (cmp_hit),
    .wrap_hit      (wrap_hit)
  );

  evtmr_flags #(.NF(NF)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr     (stat_rd),
    .mask    (irq_mask),
    .flags   (flags),
    .irq     (irq)
  );

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == '0) |-> !irq);

  assert_stop_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !cmd_vld |=> !running);

endmodule

// File: tb/sim_cmp_event_timer.sv
module sim_cmp_event_timer;
  localparam int CW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [2:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  always #4 clk = ~clk;

  cmp_event_timer #(.CNT_W(CW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state, derived from the requirements
  logic [CW-1:0] m_cnt, m_cmp;
  logic          m_run, m_stop;
  logic [1:0]    m_flg, m_msk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return DW'(m_stop);
      3'd1: return DW'(m_cmp);
      3'd3: return DW'({m_run, m_flg});
      3'd6: return DW'(m_msk);
      3'd7: return DW'(m_cnt);
      default: return '0;
    endcase
  endfunction

  function automatic string tag_for(input logic [2:0] a);
    case (a)
      3'd3: return "R8 status read";
      3'd6: return "R9 mask read";
      3'd7: return "R2 count read";
      default: return "R10 register read";
    endcase
  endfunction

  // one clock cycle of stimulus; called at a falling edge
  task automatic step(input bit tk, input bit wr, input bit rd, input logic [2:0] a,
                      input logic [DW-1:0] d, output logic [DW-1:0] got);
    logic [DW-1:0] exp_rd;
    logic [1:0]    ev;
    int            nv;
    exp_rd = exp_read(a);
    tick_en = tk; wr_en = wr; rd_en = rd; addr = a; wdata = d;
    ev = 2'b00;
    if (wr && a == 3'd2) begin
      if (d[2]) m_cnt = '0;
      if (d[1]) m_run = 1'b0;
      else if (d[0]) m_run = 1'b1;
    end else if (m_run && tk) begin
      nv = int'(m_cnt) + 1;
      if (nv == (1 << CW)) begin nv = 0; ev[1] = 1'b1; end
      if (nv == int'(m_cmp)) begin
        ev[0] = 1'b1; m_cnt = '0;
        if (m_stop) m_run = 1'b0;
      end else begin
        m_cnt = CW'(nv);
      end
    end
    if (rd && a == 3'd3) m_flg = 2'b00;
    m_flg = m_flg | ev;
    if (wr) begin
      case (a)
        3'd0: m_stop = d[0];
        3'd1: m_cmp = d[CW-1:0];
        3'd4: m_msk = m_msk | d[1:0];
        3'd5: m_msk = m_msk & ~d[1:0];
        default: ;
      endcase
    end
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    got = rdata;
    if (rd) check(tag_for(a), rdata, exp_rd);
    else    check("R10 idle rdata", rdata, '0);
    check("R9 irq", irq, |(m_flg & m_msk));
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] g;
    step(0, 1, 0, a, d, g);
  endtask

  task automatic tk(input int n);
    logic [DW-1:0] g;
    for (int i = 0; i < n; i++) step(1, 0, 0, 3'd0, '0, g);
  endtask

  task automatic rd_expect(input logic [2:0] a, input logic [DW-1:0] expv, input string req);
    logic [DW-1:0] g;
    step(0, 0, 1, a, '0, g);
    check(req, g, expv);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] g;
    m_cnt = '0; m_cmp = '0; m_run = 0; m_stop = 0; m_flg = '0; m_msk = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq after reset", irq, 0);
    rd_expect(3'd0, 16'h0, "R1 mode");
    rd_expect(3'd1, 16'h0, "R1 compare");
    rd_expect(3'd3, 16'h0, "R1 status");
    rd_expect(3'd6, 16'h0, "R1 mask");
    rd_expect(3'd7, 16'h0, "R1 count");

    // R2 counting and holding
    wr(3'd1, 16'd5);
    wr(3'd2, 16'b101);
    tk(4);
    rd_expect(3'd7, 16'd4, "R2 count after 4 ticks");
    repeat (3) step(0, 0, 0, 3'd0, '0, g);
    rd_expect(3'd7, 16'd4, "R2 count holds without tick");

    // R3 compare match on the fifth tick
    tk(1);
    rd_expect(3'd3, 16'd5, "R3 compare flag set");
    rd_expect(3'd3, 16'd4, "R8 flags cleared by read");

    // R4 periodic restart
    tk(5);
    rd_expect(3'd3, 16'd5, "R4 second period event");
    rd_expect(3'd7, 16'd0, "R4 count restarted");

    // R9 interrupt masking
    wr(3'd4, 16'd1);
    rd_expect(3'd6, 16'd1, "R9 mask set");
    tk(5);
    check("R9 irq raised", irq, 1);
    rd_expect(3'd3, 16'd5, "R9 status with irq");
    check("R9 irq cleared", irq, 0);
    wr(3'd5, 16'd1);
    rd_expect(3'd6, 16'd0, "R9 mask cleared");

    // R5 one-shot
    wr(3'd0, 16'd1);
    wr(3'd1, 16'd3);
    wr(3'd2, 16'b101);
    tk(3);
    rd_expect(3'd3, 16'd1, "R5 one-shot stopped with flag");
    tk(5);
    rd_expect(3'd7, 16'd0, "R5 count stays zero");
    rd_expect(3'd3, 16'd0, "R5 no second event");

    // R6 disable wins, trigger alone
    wr(3'd0, 16'd0);
    wr(3'd1, 16'd10);
    wr(3'd2, 16'b011);
    rd_expect(3'd3, 16'd0, "R6 disable wins over enable");
    wr(3'd2, 16'b001);
    tk(3);
    wr(3'd2, 16'b100);
    rd_expect(3'd3, 16'd4, "R6 trigger keeps running");
    rd_expect(3'd7, 16'd0, "R6 trigger zeroes count");
    tk(2);
    rd_expect(3'd7, 16'd2, "R6 count resumes after trigger");

    // R8 read and event at the same edge
    tk(7);
    step(1, 0, 1, 3'd3, '0, g);
    check("R8 pre-edge status", g, 16'd4);
    rd_expect(3'd3, 16'd5, "R8 same-edge event kept");

    // R10 read-only and write-only addresses
    wr(3'd7, 16'h1234);
    wr(3'd3, 16'h0003);
    wr(3'd6, 16'h0003);
    rd_expect(3'd7, 16'd0, "R10 count ignores write");
    rd_expect(3'd3, 16'd4, "R10 status ignores write");
    rd_expect(3'd6, 16'd0, "R10 mask read ignores write");
    rd_expect(3'd2, 16'd0, "R10 control reads zero");
    rd_expect(3'd1, 16'd10, "R10 compare readback");

    // R7 compare zero matches on the wrap, with wrap flag
    wr(3'd1, 16'd0);
    wr(3'd2, 16'b101);
    tk(65535);
    rd_expect(3'd7, 16'hFFFF, "R7 count at top");
    rd_expect(3'd3, 16'd4, "R7 no event before wrap");
    tk(1);
    rd_expect(3'd3, 16'd7, "R7 wrap and compare together");

    // R7 wrap alone when compare lies below the count
    tk(10);
    wr(3'd1, 16'd5);
    tk(65526);
    rd_expect(3'd3, 16'd6, "R7 wrap flag alone");
    rd_expect(3'd7, 16'd0, "R7 count after wrap");

    // random mix
    void'($urandom(32'd20240));
    wr(3'd2, 16'b110);
    for (int i = 0; i < 15000; i++) begin
      bit          t;
      int          op;
      logic [2:0]  a;
      logic [DW-1:0] d;
      t  = bit'($urandom % 2);
      op = int'($urandom % 4);
      a  = 3'($urandom % 8);
      case (a)
        3'd1:    d = DW'(1 + ($urandom % 12));
        3'd2:    d = DW'($urandom % 8);
        default: d = DW'($urandom % 4);
      endcase
      if (op == 1)      step(t, 1, 0, a, d, g);
      else if (op == 2) step(t, 0, 1, a, '0, g);
      else              step(t, 0, 0, 3'd0, '0, g);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule